// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This block watches a stream of CPU bus cycles and raises a break request when a configured condition is seen. It has two comparison channels, A and B. Each channel checks the cycle address under a per-bit mask. Each channel can also compare an 8-bit address-space ID, and it filters on cycle type: fetch or data access, read or write, optional operand size, and optionally CPU-only cycles. Channel B can also compare the data bus under a mask.

The channels can run independently, where either one breaks on its own. They can also run as a sequence, where a channel A hit arms the block and a later channel B hit breaks. A fetch condition can break before the matched instruction executes, which happens straight after the fetch. It can instead break after the instruction has executed, which is signalled when the instruction-retire strobe arrives. Software programs the block through a flat word-indexed write/read port and reads back sticky per-channel match flags and the sequence arm state.

Top module: `bus_break_top`

## Requirements
- R1: A channel's address matches when every address bit whose mask bit is 0 equals the compare value; a mask bit of 1 excludes that bit (base 0x8010, mask 0x6 hits 0x8010..0x8016 even addresses and misses 0x8011 and 0x8018).
- R2: When condition bit 16 (data compare enable) is set on channel B, a hit also needs every data bit whose data-mask bit is 0 to equal the data compare value; a data mask of zero requires all bits to match.
- R3: When condition bit 7 (ID compare enable) is set, a hit needs the bus ID to equal condition bits 15:8; when it is clear the bus ID is ignored.
- R4: Condition bit 0 enables the channel. A hit needs the bus fetch flag to equal bit 1 and the bus write flag to equal bit 2. When bit 3 is set, the bus size must equal bits 5:4. When bit 17 is set, the cycle must come from the CPU.
- R5: With control bit 0 (sequence mode) clear, a before-execution hit on either channel gives a break pulse in the cycle after the bus cycle.
- R6: When both channels hit in the same cycle in independent mode, the break reports channel A (`brk_chan` = 0).
- R7: With sequence mode set, a channel A hit only sets the arm flag (control bit 1) and gives no break; a later channel B hit while armed breaks with `brk_chan` = 1; a channel B hit while unarmed gives no break.
- R8: The arm flag is cleared by a sequence break, by writing 1 to control bit 2, and by any control write that changes the mode bit.
- R9: A fetch hit with condition bit 6 (after execution) set breaks in the cycle after the next `retire` strobe, with `brk_after` = 1, and not after the fetch cycle itself.
- R10: Control bits 4 and 5 are sticky match flags for channels A and B, set on every hit; a control write with 0 in a flag bit clears it, and a 1 leaves it unchanged.
- R11: `brk_req` is a single-cycle pulse; `brk_chan` and `brk_after` are valid only in that cycle.
- R12: Register word indices are 0 A address, 1 A mask, 2 A condition, 3 B address, 4 B mask, 5 B condition, 6 B data, 7 B data mask, 8 control. All of them reset to zero and read back what was written. Control bit 2 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` |
| bus_valid | input | 1 | A bus cycle is present |
| bus_cpu | input | 1 | Cycle comes from the CPU |
| bus_fetch | input | 1 | 1 for instruction fetch, 0 for data access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | Operand size code |
| bus_addr | input | AW | Cycle address |
| bus_data | input | DW | Cycle data |
| bus_asid | input | 8 | Address-space ID of the cycle |
| retire | input | 1 | Instruction-retire strobe |
| brk_req | output | 1 | Break request pulse |
| brk_chan | output | 1 | Channel that caused the break (0 A, 1 B) |
| brk_after | output | 1 | Break is after execution |

## Verification
The bench builds the block with its default 32-bit address and data widths. At that width the mask and data-mask cases are checked on the full register width, and bit 0 of the address can be shown to stay in the compare while bits 1 and 2 drop out. The narrow 4-bit register index covers the whole map, so every register and the control word can be read back directly through the port.

// File: rtl/brk_pkg.sv
package brk_pkg;
    localparam int ID_W = 8;

    // per-channel condition word, low 18 bits of the condition register
    typedef struct packed {
        logic            cpu_only;
        logic            data_en;
        logic [ID_W-1:0] id;
        logic            id_en;
        logic            after;
        logic [1:0]      size;
        logic            size_chk;
        logic            wr;
        logic            fetch;
        logic            en;
    } cond_t;

    localparam int COND_W = $bits(cond_t);

    localparam logic [3:0] RG_A_ADDR  = 4'd0;
    localparam logic [3:0] RG_A_MASK  = 4'd1;
    localparam logic [3:0] RG_A_COND  = 4'd2;
    localparam logic [3:0] RG_B_ADDR  = 4'd3;
    localparam logic [3:0] RG_B_MASK  = 4'd4;
    localparam logic [3:0] RG_B_COND  = 4'd5;
    localparam logic [3:0] RG_B_DATA  = 4'd6;
    localparam logic [3:0] RG_B_DMASK = 4'd7;
    localparam logic [3:0] RG_CTRL    = 4'd8;

    localparam int CB_SEQ   = 0;
    localparam int CB_ARMED = 1;
    localparam int CB_CLR   = 2;
    localparam int CB_FLAGA = 4;
    localparam int CB_FLAGB = 5;
endpackage

// File: rtl/brk_match.sv
module brk_match
    import brk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic            bus_valid,
    input  logic            bus_cpu,
    input  logic            bus_fetch,
    input  logic            bus_write,
    input  logic [1:0]      bus_size,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_data,
    input  logic [ID_W-1:0] bus_asid,
    input  logic [AW-1:0]   cmp_addr,
    input  logic [AW-1:0]   cmp_mask,
    input  logic [DW-1:0]   cmp_data,
    input  logic [DW-1:0]   cmp_dmask,
    input  cond_t           cond,
    output logic            hit_now,
    output logic            hit_late
);
    logic addr_ok, data_ok, id_ok, kind_ok, hit;

    always_comb begin
        addr_ok = ((bus_addr ^ cmp_addr) & ~cmp_mask) == '0;
        data_ok = !cond.data_en || (((bus_data ^ cmp_data) & ~cmp_dmask) == '0);
        id_ok   = !cond.id_en || (bus_asid == cond.id);
        kind_ok = (bus_fetch == cond.fetch) && (bus_write == cond.wr)
                  && (!cond.size_chk || (bus_size == cond.size))
                  && (!cond.cpu_only || bus_cpu);
        hit      = bus_valid && cond.en && addr_ok && data_ok && id_ok && kind_ok;
        hit_late = hit && cond.fetch && cond.after;
        hit_now  = hit && !hit_late;
    end
endmodule

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [3:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic [2:0]    stat,      // {flag_b, flag_a, armed}
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] ch_addr [2],
    output logic [AW-1:0] ch_mask [2],
    output cond_t         ch_cond [2],
    output logic [DW-1:0] b_data,
    output logic [DW-1:0] b_dmask,
    output logic          seq_mode
);
    typedef struct packed {
        logic [AW-1:0]     a_addr, a_mask, b_addr, b_mask;
        logic [COND_W-1:0] a_cond, b_cond;
        logic [DW-1:0]     b_data, b_dmask;
        logic              seq;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            unique case (addr)
                RG_A_ADDR:  r_d.a_addr  = AW'(wdata);
                RG_A_MASK:  r_d.a_mask  = AW'(wdata);
                RG_A_COND:  r_d.a_cond  = wdata[COND_W-1:0];
                RG_B_ADDR:  r_d.b_addr  = AW'(wdata);
                RG_B_MASK:  r_d.b_mask  = AW'(wdata);
                RG_B_COND:  r_d.b_cond  = wdata[COND_W-1:0];
                RG_B_DATA:  r_d.b_data  = wdata;
                RG_B_DMASK: r_d.b_dmask = wdata;
                RG_CTRL:    r_d.seq     = wdata[CB_SEQ];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (addr)
            RG_A_ADDR:  rdata = DW'(r_q.a_addr);
            RG_A_MASK:  rdata = DW'(r_q.a_mask);
            RG_A_COND:  rdata = DW'(r_q.a_cond);
            RG_B_ADDR:  rdata = DW'(r_q.b_addr);
            RG_B_MASK:  rdata = DW'(r_q.b_mask);
            RG_B_COND:  rdata = DW'(r_q.b_cond);
            RG_B_DATA:  rdata = r_q.b_data;
            RG_B_DMASK: rdata = r_q.b_dmask;
            RG_CTRL:    rdata = DW'({stat[2:1], 2'b00, stat[0], r_q.seq});
            default:    rdata = '0;
        endcase
    end

    assign ch_addr[0] = r_q.a_addr;
    assign ch_addr[1] = r_q.b_addr;
    assign ch_mask[0] = r_q.a_mask;
    assign ch_mask[1] = r_q.b_mask;
    assign ch_cond[0] = cond_t'(r_q.a_cond);
    assign ch_cond[1] = cond_t'(r_q.b_cond);
    assign b_data     = r_q.b_data;
    assign b_dmask    = r_q.b_dmask;
    assign seq_mode   = r_q.seq;

    // a write to the control word leaves the mode bit equal to the written value
    AST_CTRL_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == RG_CTRL) |=> (seq_mode == $past(wdata[CB_SEQ]))); // R12
endmodule

// File: rtl/bus_break_top.sv
module bus_break_top
    import brk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [3:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            bus_valid,
    input  logic            bus_cpu,
    input  logic            bus_fetch,
    input  logic            bus_write,
    input  logic [1:0]      bus_size,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_data,
    input  logic [ID_W-1:0] bus_asid,
    input  logic            retire,
    output logic            brk_req,
    output logic            brk_chan,
    output logic            brk_after
);
    localparam int NCH = 2;

    typedef struct packed {
        logic armed;
        logic flag_a, flag_b;
        logic pend_a, pend_b;
        logic brk, brk_ch, brk_aft;
    } st_t;

    st_t s_d, s_q;

    logic [AW-1:0] ch_addr [NCH];
    logic [AW-1:0] ch_mask [NCH];
    cond_t         ch_cond [NCH];
    logic [DW-1:0] b_data, b_dmask;
    logic          seq_mode;
    logic [NCH-1:0] hit_now, hit_late, hit_any;

    brk_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .stat({s_q.flag_b, s_q.flag_a, s_q.armed}), .rdata(reg_rdata),
        .ch_addr(ch_addr), .ch_mask(ch_mask), .ch_cond(ch_cond),
        .b_data(b_data), .b_dmask(b_dmask), .seq_mode(seq_mode)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // channel A has no data value: its data compare is fully masked
        localparam bit HAS_DATA = (c == 1);
        brk_match #(.AW(AW), .DW(DW)) u_match (
            .bus_valid(bus_valid), .bus_cpu(bus_cpu), .bus_fetch(bus_fetch),
            .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
            .bus_data(bus_data), .bus_asid(bus_asid),
            .cmp_addr(ch_addr[c]), .cmp_mask(ch_mask[c]),
            .cmp_data(HAS_DATA ? b_data : '0),
            .cmp_dmask(HAS_DATA ? b_dmask : '1),
            .cond(ch_cond[c]), .hit_now(hit_now[c]), .hit_late(hit_late[c])
        );
    end

    assign hit_any = hit_now | hit_late;

    logic ctrl_wr, mode_chg, serve_a, serve_b, b_fire;

    always_comb begin
        s_d         = s_q;
        s_d.brk     = 1'b0;
        s_d.brk_ch  = 1'b0;
        s_d.brk_aft = 1'b0;

        ctrl_wr  = reg_we && (reg_addr == RG_CTRL);
        mode_chg = ctrl_wr && (reg_wdata[CB_SEQ] != seq_mode);

        // sticky flags: software clears with 0, a hit sets (set wins)
        if (ctrl_wr) begin
            s_d.flag_a = s_q.flag_a & reg_wdata[CB_FLAGA];
            s_d.flag_b = s_q.flag_b & reg_wdata[CB_FLAGB];
        end
        s_d.flag_a = s_d.flag_a | hit_any[0];
        s_d.flag_b = s_d.flag_b | hit_any[1];

        // retire strobe serves a pending after-execution break, A first
        serve_a = retire && s_q.pend_a;
        serve_b = retire && !s_q.pend_a && s_q.pend_b;
        s_d.pend_a = s_q.pend_a & ~serve_a;
        s_d.pend_b = s_q.pend_b & ~serve_b;

        b_fire = 1'b0;
        if (seq_mode) begin
            b_fire = hit_any[1] && s_q.armed;
            if (b_fire) begin
                s_d.armed = 1'b0;
                if (hit_now[1]) begin
                    s_d.brk    = 1'b1;
                    s_d.brk_ch = 1'b1;
                end else begin
                    s_d.pend_b = 1'b1;
                end
            end else if (hit_any[0]) begin
                s_d.armed = 1'b1;
            end
        end else begin
            s_d.pend_a = s_d.pend_a | hit_late[0];
            s_d.pend_b = s_d.pend_b | hit_late[1];
            if (hit_now[0]) begin
                s_d.brk = 1'b1;
            end else if (hit_now[1]) begin
                s_d.brk    = 1'b1;
                s_d.brk_ch = 1'b1;
            end
        end

        if (serve_a || serve_b) begin
            s_d.brk     = 1'b1;
            s_d.brk_ch  = serve_b;
            s_d.brk_aft = 1'b1;
        end

        if (ctrl_wr && (reg_wdata[CB_CLR] || mode_chg)) s_d.armed = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign brk_req   = s_q.brk;
    assign brk_chan  = s_q.brk_ch;
    assign brk_after = s_q.brk_aft;

    AST_SEQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && !brk_after && $past(seq_mode)) |-> $past(s_q.armed)); // R7
    AST_ARM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && !brk_after) |-> !s_q.armed); // R8
    AST_AFTER_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && brk_after) |-> $past(retire)); // R9
    AST_FLAG_WITH_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && !brk_after && !brk_chan) |-> s_q.flag_a); // R10
    AST_MODE_CLEARS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_chg) |-> !s_q.armed); // R8
endmodule

// File: tb/bus_break_top_test.sv
module bus_break_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_valid = 1'b0, bus_cpu = 1'b1, bus_fetch = 1'b0, bus_write = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_addr = '0, bus_data = '0;
    logic [7:0]  bus_asid = '0;
    logic        retire = 1'b0;
    logic        brk_req, brk_chan, brk_after;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bus_break_top uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_cpu(bus_cpu), .bus_fetch(bus_fetch), .bus_write(bus_write),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_asid(bus_asid), .retire(retire), .brk_req(brk_req),
        .brk_chan(brk_chan), .brk_after(brk_after)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // condition word: en[0] fetch[1] wr[2] size_chk[3] size[5:4] after[6] id_en[7] id[15:8] data_en[16] cpu_only[17]
    function automatic logic [31:0] mk(input bit fetch, input bit wr, input bit szc,
                                       input logic [1:0] sz, input bit aft, input bit iden,
                                       input logic [7:0] id, input bit den, input bit cpuo);
        return {14'd0, cpuo, den, id, iden, aft, sz, szc, wr, fetch, 1'b1};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #2;
        check(tag, reg_rdata, exp);
    endtask

    // one bus cycle; returns at the next falling edge, where the registered break is visible
    task automatic bus(input logic [31:0] a, input logic [31:0] d, input logic [7:0] id,
                       input bit f, input bit w, input logic [1:0] sz, input bit cpu);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_asid = id;
        bus_fetch = f; bus_write = w; bus_size = sz; bus_cpu = cpu;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic brk_chk(input string tag, input bit req, input bit ch, input bit aft);
        check({tag, " req"}, 32'(brk_req), 32'(req));
        if (req) begin
            check({tag, " chan"}, 32'(brk_chan), 32'(ch));
            check({tag, " after"}, 32'(brk_after), 32'(aft));
        end
    endtask

    task automatic quiet();
        wr(4'd2, 32'd0); wr(4'd5, 32'd0); wr(4'd8, 32'd0);
        wr(4'd1, 32'd0); wr(4'd4, 32'd0); wr(4'd7, 32'd0);
    endtask

    task automatic t_reset();
        check("R11 reset brk_req", 32'(brk_req), 32'd0);
        rd_chk("R12 reset ctrl", 4'd8, 32'd0);
        rd_chk("R12 reset A addr", 4'd0, 32'd0);
        wr(4'd0, 32'h0000_0404);
        rd_chk("R12 readback A addr", 4'd0, 32'h0000_0404);
        wr(4'd8, 32'h0000_0005);
        rd_chk("R12 ctrl clear bit reads 0", 4'd8, 32'h0000_0001);
        wr(4'd8, 32'h0);
    endtask

    task automatic t_mask();
        quiet();
        wr(4'd0, 32'h8010); wr(4'd1, 32'h6);
        wr(4'd2, mk(1, 0, 0, 0, 0, 0, 0, 0, 0));
        bus(32'h8016, 0, 0, 1, 0, 1, 1); brk_chk("R1 R5 masked hit 8016", 1, 0, 0);
        bus(32'h8010, 0, 0, 1, 0, 1, 1); brk_chk("R1 base hit 8010", 1, 0, 0);
        bus(32'h8011, 0, 0, 1, 0, 1, 1); brk_chk("R1 bit0 not masked", 0, 0, 0);
        bus(32'h8018, 0, 0, 1, 0, 1, 1); brk_chk("R1 outside window", 0, 0, 0);
        bus(32'h8012, 0, 0, 1, 0, 1, 1);
        @(negedge clk); brk_chk("R11 pulse one cycle", 0, 0, 0);
    endtask

    task automatic t_id();
        quiet();
        wr(4'd0, 32'h500);
        wr(4'd2, mk(1, 0, 0, 0, 0, 1, 8'h80, 0, 0));
        bus(32'h500, 0, 8'h70, 1, 0, 0, 1); brk_chk("R3 id mismatch", 0, 0, 0);
        bus(32'h500, 0, 8'h80, 1, 0, 0, 1); brk_chk("R3 id match", 1, 0, 0);
        wr(4'd2, mk(1, 0, 0, 0, 0, 0, 8'h80, 0, 0));
        bus(32'h500, 0, 8'h70, 1, 0, 0, 1); brk_chk("R3 id ignored", 1, 0, 0);
    endtask

    task automatic t_kind();
        quiet();
        wr(4'd0, 32'h2000);
        wr(4'd2, mk(0, 1, 1, 2'd1, 0, 0, 0, 0, 1));
        bus(32'h2000, 0, 0, 1, 0, 1, 1); brk_chk("R4 fetch filtered", 0, 0, 0);
        bus(32'h2000, 0, 0, 0, 0, 1, 1); brk_chk("R4 read filtered", 0, 0, 0);
        bus(32'h2000, 0, 0, 0, 1, 0, 1); brk_chk("R4 size filtered", 0, 0, 0);
        bus(32'h2000, 0, 0, 0, 1, 1, 0); brk_chk("R4 non-CPU filtered", 0, 0, 0);
        bus(32'h2000, 0, 0, 0, 1, 1, 1); brk_chk("R4 write word hit", 1, 0, 0);
        wr(4'd2, mk(0, 1, 0, 2'd1, 0, 0, 0, 0, 1));
        bus(32'h2000, 0, 0, 0, 1, 0, 1); brk_chk("R4 size not checked", 1, 0, 0);
    endtask

    task automatic t_data();
        quiet();
        wr(4'd3, 32'h3000); wr(4'd6, 32'h1234);
        wr(4'd5, mk(0, 1, 0, 0, 0, 0, 0, 1, 0));
        bus(32'h3000, 32'h1234, 0, 0, 1, 2, 1); brk_chk("R2 data match", 1, 1, 0);
        bus(32'h3000, 32'h1235, 0, 0, 1, 2, 1); brk_chk("R2 data mismatch", 0, 0, 0);
        wr(4'd7, 32'hF);
        bus(32'h3000, 32'h1235, 0, 0, 1, 2, 1); brk_chk("R2 data masked", 1, 1, 0);
    endtask

    task automatic t_prio_flags();
        quiet();
        wr(4'd0, 32'h100); wr(4'd3, 32'h100);
        wr(4'd2, mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(4'd5, mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
        bus(32'h100, 0, 0, 0, 0, 2, 1); brk_chk("R6 both hit reports A", 1, 0, 0);
        rd_chk("R10 both flags set", 4'd8, 32'h30);
        wr(4'd8, 32'h20);
        rd_chk("R10 clear A keep B", 4'd8, 32'h20);
        wr(4'd8, 32'h30);
        rd_chk("R10 write 1 does not set", 4'd8, 32'h20);
        wr(4'd8, 32'h0);
        rd_chk("R10 all cleared", 4'd8, 32'h0);
    endtask

    task automatic t_seq();
        quiet();
        wr(4'd8, 32'h1);
        wr(4'd0, 32'h37226); wr(4'd3, 32'h3722E);
        wr(4'd2, mk(1, 0, 1, 2'd1, 0, 1, 8'h80, 0, 1));
        wr(4'd5, mk(1, 0, 1, 2'd1, 0, 1, 8'h70, 0, 1));
        bus(32'h3722E, 0, 8'h70, 1, 0, 1, 1); brk_chk("R7 B unarmed no break", 0, 0, 0);
        bus(32'h37226, 0, 8'h80, 1, 0, 1, 1); brk_chk("R7 A only arms", 0, 0, 0);
        rd_chk("R7 armed", 4'd8, 32'h33);
        bus(32'h3722E, 0, 8'h70, 1, 0, 1, 1); brk_chk("R7 B after A breaks", 1, 1, 0);
        rd_chk("R8 break clears arm", 4'd8, 32'h31);
        bus(32'h37226, 0, 8'h80, 1, 0, 1, 1);
        wr(4'd8, 32'h5);
        rd_chk("R8 software clear", 4'd8, 32'h1);
        bus(32'h3722E, 0, 8'h70, 1, 0, 1, 1); brk_chk("R8 no break after clear", 0, 0, 0);
        bus(32'h37226, 0, 8'h80, 1, 0, 1, 1);
        wr(4'd8, 32'h0);
        rd_chk("R8 mode change clears", 4'd8, 32'h0);
        wr(4'd8, 32'h1);
        bus(32'h3722E, 0, 8'h70, 1, 0, 1, 1); brk_chk("R8 no break after mode change", 0, 0, 0);
    endtask

    task automatic t_after();
        quiet();
        wr(4'd0, 32'h404);
        wr(4'd2, mk(1, 0, 0, 0, 1, 0, 0, 0, 0));
        bus(32'h404, 0, 0, 1, 0, 1, 1); brk_chk("R9 no break on fetch", 0, 0, 0);
        @(negedge clk); brk_chk("R9 waits for retire", 0, 0, 0);
        retire = 1'b1;
        @(negedge clk);
        retire = 1'b0;
        brk_chk("R9 break after retire", 1, 0, 1);
        @(negedge clk); brk_chk("R11 after pulse ends", 0, 0, 0);
        retire = 1'b1;
        @(negedge clk);
        retire = 1'b0;
        brk_chk("R9 retire without pending", 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_id();
        t_kind();
        t_data();
        t_prio_flags();
        t_seq();
        t_after();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule